// File: doc/BRIEF.md
# Bit-packed instruction field parser

This block walks an instruction store in which instructions of varying length are packed back to back at arbitrary bit positions, with no padding and no byte alignment. It keeps a bit pointer into the store and reads two neighbouring 32-bit words each cycle through a pair of combinational read ports. From that 64-bit window it pulls out one field per cycle, so a field that crosses a word boundary costs nothing extra.

Every instruction opens with a class field. The class sets everything that follows: how many operand references there are, how wide each one is, how wide the format field is and whether an opcode is present. The format field then says, operand by operand, whether that operand is an explicit reference carried in the bit stream or an implicit operand-stack reference that takes no bits. When an instruction is complete, its record (raw class, format, up to three operands with flags, opcode, start bit and length in bits) is offered on a valid/ready output. The pointer then moves to the bit right after it.

The parser starts from a bit address given with a start pulse. If a field would reach past the last bit of the store, the parser flags an overrun and halts rather than wrapping.

Top module: `bit_instr_parser`

## Requirements
- R1: Bit `b` of the store is bit `b mod 32` of word `b / 32`. A field's first bit in the stream becomes bit 0 of its value, and a field that crosses a word boundary is assembled from both words.
- R2: The first 4 bits of an instruction are a prefix `p`. For `p` of 0 to 13 the class is 4 bits long and its class id is `p`. For `p` of 14 or 15 the class is 6 bits long and its class id is `14 + 4*p[0] + x`, where `x` is the value of class bits 5:4. `out_cls` carries the raw class bits, zero-extended to 6 bits.
- R3: For class id `c`, the operand count is `c mod 4` and the format width equals that count. Each operand length is `min(16, 4*(c/4 + 1))`. The opcode width is 0 for `c = 21`, `2 + (c mod 3)` for `c < 14`, and 5 otherwise.
- R4: Fields come in the order class, format, operand 0..n-1, opcode. Format bit `i` = 1 makes operand `i` explicit: it takes the operand length in bits and has its flag in `out_opnd_vld[i]` set. Format bit `i` = 0 makes operand `i` an implicit stack reference: it takes no bits, its flag is clear and its value reads as zero.
- R5: Records are produced in stream order. Each one gives its start bit in `out_start` and its total bit count in `out_len`, and the next instruction begins at `out_start + out_len`.
- R6: While `out_valid` is high and `out_ready` low, the record stays unchanged. No further instruction is parsed until the record is accepted.
- R7: If any field would extend past bit `2^PTR_W - 1`, `overrun` rises, no record is offered for that instruction, and the parser stays halted until the next start. An instruction that ends exactly on the last bit is still delivered.
- R8: A start pulse loads the pointer from `start_bit`, clears `overrun` and drops any pending record. In the following cycle `out_valid` is low.
- R9: Out of reset, `out_valid` and `overrun` are low and the parser stays idle until a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin parsing at `start_bit` |
| start_bit | input | PTR_W | Bit address of the first instruction |
| mem_addr0 | output | PTR_W-5 | Word holding the current pointer |
| mem_addr1 | output | PTR_W-5 | Following word (wraps) |
| mem_rdata0 | input | 32 | Contents of `mem_addr0` |
| mem_rdata1 | input | 32 | Contents of `mem_addr1` |
| out_valid | output | 1 | Decoded record available |
| out_ready | input | 1 | Consumer accepts the record |
| out_cls | output | 6 | Raw class bits |
| out_fmt | output | 3 | Format bits |
| out_opnd | output | 3*OPND_W | Operand values, operand `i` at bits `i*OPND_W +: OPND_W` |
| out_opnd_vld | output | 3 | Explicit-operand flags |
| out_opc | output | 5 | Opcode bits |
| out_start | output | PTR_W | Start bit of the instruction |
| out_len | output | LEN_W | Instruction length in bits |
| overrun | output | 1 | Store end exceeded; parser halted |

## Verification
The bench builds the parser with `PTR_W = 10`, which gives a 1024-bit store of 32 words, and with the default 16-bit operands. With a store that small, every random stream runs into the store end within a few dozen instructions. Overrun in the class, format, operand and opcode fields, as well as an instruction ending exactly on the last bit, are therefore reached in every run rather than needing 65,536 bits of content. A random bit fill is always a legal stream, so random start addresses exercise class extension and operands that straddle word boundaries at every bit offset.

// File: rtl/ipar_pkg.sv
package ipar_pkg;

    localparam int CLS_RAW_W  = 6;
    localparam int CLS_ID_W   = 5;
    localparam int PREFIX_W   = 4;
    localparam int FMT_W      = 3;
    localparam int OPC_W      = 5;
    localparam int N_OPND     = 3;
    localparam int FLEN_W     = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLS,
        ST_FMT,
        ST_OPD,
        ST_OPC,
        ST_OUT,
        ST_HALT
    } ipar_state_e;

    typedef struct packed {
        logic [1:0]        order;
        logic [FLEN_W-1:0] opnd_len;
        logic [2:0]        fmt_w;
        logic [2:0]        opc_w;
    } ipar_layout_t;

endpackage

// File: rtl/ipar_class_rom.sv
module ipar_class_rom
    import ipar_pkg::*;
#(
    parameter int OPND_STEP = 4,
    parameter int OPND_MAX  = 16,
    parameter int SHORT_CLS = 14,
    parameter int EXT_OPC_W = 5
) (
    input  logic [CLS_ID_W-1:0] cls_id,
    output ipar_layout_t        lay
);

    localparam int LAST_CLS = SHORT_CLS + 7;

    int len_calc;

    always_comb begin
        len_calc = OPND_STEP * (int'(cls_id) / 4 + 1);
        if (len_calc > OPND_MAX) begin
            len_calc = OPND_MAX;
        end
        lay.order    = cls_id[1:0];
        lay.fmt_w    = {1'b0, cls_id[1:0]};
        lay.opnd_len = FLEN_W'(len_calc);
        if (cls_id == CLS_ID_W'(LAST_CLS)) begin
            lay.opc_w = 3'd0;
        end else if (cls_id < CLS_ID_W'(SHORT_CLS)) begin
            lay.opc_w = 3'(2 + int'(cls_id) % 3);
        end else begin
            lay.opc_w = 3'(EXT_OPC_W);
        end
    end

endmodule

// File: rtl/ipar_field_pick.sv
module ipar_field_pick #(
    parameter int WIN_W = 64,
    parameter int OFF_W = 5,
    parameter int LEN_W = 5,
    parameter int MAX_W = 16
) (
    input  logic [WIN_W-1:0] win,
    input  logic [OFF_W-1:0] off,
    input  logic [LEN_W-1:0] len,
    output logic [MAX_W-1:0] fld
);

    logic [WIN_W-1:0] shifted;

    assign shifted = win >> off;

    for (genvar i = 0; i < MAX_W; i++) begin : g_mask
        assign fld[i] = shifted[i] & (len > LEN_W'(i));
    end

endmodule

// File: rtl/bit_instr_parser.sv
module bit_instr_parser
    import ipar_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int OPND_W = 16,
    parameter int WA_W   = PTR_W - 5,
    parameter int LEN_W  = $clog2(15 + 3 * OPND_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [PTR_W-1:0]           start_bit,
    output logic [WA_W-1:0]            mem_addr0,
    output logic [WA_W-1:0]            mem_addr1,
    input  logic [31:0]                mem_rdata0,
    input  logic [31:0]                mem_rdata1,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [CLS_RAW_W-1:0]       out_cls,
    output logic [FMT_W-1:0]           out_fmt,
    output logic [N_OPND*OPND_W-1:0]   out_opnd,
    output logic [N_OPND-1:0]          out_opnd_vld,
    output logic [OPC_W-1:0]           out_opc,
    output logic [PTR_W-1:0]           out_start,
    output logic [LEN_W-1:0]           out_len,
    output logic                       overrun
);

    localparam int WORD_W     = 32;
    localparam int OFF_W      = $clog2(WORD_W);
    localparam int WIN_W      = 2 * WORD_W;
    localparam int PICK_W     = (OPND_W > CLS_RAW_W) ? OPND_W : CLS_RAW_W;
    localparam int SHORT_CLS  = 14;
    localparam logic [PTR_W:0] LIMIT = {1'b1, {PTR_W{1'b0}}};

    typedef struct packed {
        ipar_state_e                st;
        logic [PTR_W:0]             ptr;
        logic [PTR_W:0]             ibeg;
        logic [CLS_RAW_W-1:0]       cls;
        logic [CLS_ID_W-1:0]        cid;
        logic [FMT_W-1:0]           fmt;
        logic [N_OPND*OPND_W-1:0]   opnd;
        logic [N_OPND-1:0]          vld;
        logic [1:0]                 idx;
        logic [OPC_W-1:0]           opc;
        logic                       ovr;
    } regs_t;

    regs_t r_q, r_d;

    logic [WIN_W-1:0]   win;
    logic [FLEN_W-1:0]  pick_len;
    logic [FLEN_W-1:0]  cons_w;
    logic [PICK_W-1:0]  fld;
    logic [PTR_W:0]     ptr_adv;
    logic               fits;
    logic               is_ext;
    logic               explicit_op;
    ipar_layout_t       lay;

    // window over the current word and its successor
    assign mem_addr0 = r_q.ptr[PTR_W-1:OFF_W];
    assign mem_addr1 = r_q.ptr[PTR_W-1:OFF_W] + WA_W'(1);
    assign win       = {mem_rdata1, mem_rdata0};

    ipar_class_rom #(
        .OPND_STEP (4),
        .OPND_MAX  (OPND_W),
        .SHORT_CLS (SHORT_CLS),
        .EXT_OPC_W (OPC_W)
    ) u_rom (
        .cls_id (r_q.cid),
        .lay    (lay)
    );

    ipar_field_pick #(
        .WIN_W (WIN_W),
        .OFF_W (OFF_W),
        .LEN_W (FLEN_W),
        .MAX_W (PICK_W)
    ) u_pick (
        .win (win),
        .off (r_q.ptr[OFF_W-1:0]),
        .len (pick_len),
        .fld (fld)
    );

    assign explicit_op = r_q.fmt[r_q.idx];

    // how many bits the extractor exposes this cycle
    always_comb begin
        unique case (r_q.st)
            ST_CLS:  pick_len = FLEN_W'(CLS_RAW_W);
            ST_FMT:  pick_len = FLEN_W'(lay.fmt_w);
            ST_OPD:  pick_len = explicit_op ? lay.opnd_len : '0;
            ST_OPC:  pick_len = FLEN_W'(lay.opc_w);
            default: pick_len = '0;
        endcase
    end

    always_comb begin
        r_d    = r_q;
        is_ext = fld[PREFIX_W-1:0] >= PREFIX_W'(SHORT_CLS);

        if (r_q.st == ST_CLS) begin
            cons_w = is_ext ? FLEN_W'(CLS_RAW_W) : FLEN_W'(PREFIX_W);
        end else begin
            cons_w = pick_len;
        end
        ptr_adv = r_q.ptr + (PTR_W+1)'(cons_w);
        fits    = ptr_adv <= LIMIT;

        unique case (r_q.st)
            ST_CLS: begin
                if (fits) begin
                    r_d.ibeg = r_q.ptr;
                    r_d.ptr  = ptr_adv;
                    if (is_ext) begin
                        r_d.cls = fld[CLS_RAW_W-1:0];
                        r_d.cid = CLS_ID_W'(SHORT_CLS) + {2'b00, fld[0], fld[5:4]};
                    end else begin
                        r_d.cls = {2'b00, fld[PREFIX_W-1:0]};
                        r_d.cid = {1'b0, fld[PREFIX_W-1:0]};
                    end
                    r_d.fmt  = '0;
                    r_d.opnd = '0;
                    r_d.vld  = '0;
                    r_d.opc  = '0;
                    r_d.idx  = '0;
                    r_d.st   = ST_FMT;
                end
            end
            ST_FMT: begin
                if (fits) begin
                    r_d.fmt = fld[FMT_W-1:0];
                    r_d.ptr = ptr_adv;
                    r_d.idx = '0;
                    r_d.st  = (lay.order == 2'd0) ? ST_OPC : ST_OPD;
                end
            end
            ST_OPD: begin
                if (fits) begin
                    for (int i = 0; i < N_OPND; i++) begin
                        if (r_q.idx == 2'(i)) begin
                            r_d.opnd[i*OPND_W +: OPND_W] = explicit_op ? fld[OPND_W-1:0] : '0;
                            r_d.vld[i] = explicit_op;
                        end
                    end
                    r_d.ptr = ptr_adv;
                    r_d.idx = r_q.idx + 2'd1;
                    if (r_q.idx == lay.order - 2'd1) begin
                        r_d.st = ST_OPC;
                    end
                end
            end
            ST_OPC: begin
                if (fits) begin
                    r_d.opc = fld[OPC_W-1:0];
                    r_d.ptr = ptr_adv;
                    r_d.st  = ST_OUT;
                end
            end
            ST_OUT: begin
                if (out_ready) begin
                    r_d.st = ST_CLS;
                end
            end
            default: begin
            end
        endcase

        // any field running past the store end halts the walk
        if ((r_q.st == ST_CLS || r_q.st == ST_FMT || r_q.st == ST_OPD ||
             r_q.st == ST_OPC) && !fits) begin
            r_d.st  = ST_HALT;
            r_d.ovr = 1'b1;
        end

        if (start) begin
            r_d.st  = ST_CLS;
            r_d.ptr = {1'b0, start_bit};
            r_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid    = (r_q.st == ST_OUT);
    assign out_cls      = r_q.cls;
    assign out_fmt      = r_q.fmt;
    assign out_opnd     = r_q.opnd;
    assign out_opnd_vld = r_q.vld;
    assign out_opc      = r_q.opc;
    assign out_start    = r_q.ibeg[PTR_W-1:0];
    assign out_len      = LEN_W'(r_q.ptr - r_q.ibeg);
    assign overrun      = r_q.ovr;

endmodule

// File: rtl/bit_instr_parser_chk.sv
module bit_instr_parser_chk #(
    parameter int PTR_W  = 16,
    parameter int OPND_W = 16,
    parameter int LEN_W  = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [5:0]            out_cls,
    input logic [2:0]            out_fmt,
    input logic [3*OPND_W-1:0]   out_opnd,
    input logic [2:0]            out_opnd_vld,
    input logic [4:0]            out_opc,
    input logic [PTR_W-1:0]      out_start,
    input logic [LEN_W-1:0]      out_len,
    input logic                  overrun
);

    localparam int MAX_LEN = 14 + 3 * OPND_W;

    // R6: a stalled record does not move
    a_r6_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !start |=>
            out_valid && $stable(out_cls) && $stable(out_fmt) && $stable(out_opnd) &&
            $stable(out_opnd_vld) && $stable(out_opc) && $stable(out_start) &&
            $stable(out_len));

    // R7: overrun persists and suppresses records until restarted
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !start |=> overrun && !out_valid);

    a_r7_no_record_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !out_valid);

    // R8: start discards pending output and clears the error
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !out_valid && !overrun);

    // R4: implicit operands read as zero
    a_r4_implicit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |->
            (out_opnd_vld[0] || out_opnd[OPND_W-1:0] == '0) &&
            (out_opnd_vld[1] || out_opnd[2*OPND_W-1:OPND_W] == '0) &&
            (out_opnd_vld[2] || out_opnd[3*OPND_W-1:2*OPND_W] == '0));

    // R3: every class layout yields a length inside the legal span
    a_r3_length_span: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= LEN_W'(6)) && (out_len <= LEN_W'(MAX_LEN)));

endmodule

bind bit_instr_parser bit_instr_parser_chk #(
    .PTR_W  (PTR_W),
    .OPND_W (OPND_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_cls      (out_cls),
    .out_fmt      (out_fmt),
    .out_opnd     (out_opnd),
    .out_opnd_vld (out_opnd_vld),
    .out_opc      (out_opc),
    .out_start    (out_start),
    .out_len      (out_len),
    .overrun      (overrun)
);

// File: tb/bit_instr_parser_tb.sv
module bit_instr_parser_tb;

    localparam int PTR_W  = 10;
    localparam int OPND_W = 16;
    localparam int LIM    = 1 << PTR_W;
    localparam int NWORD  = LIM / 32;
    localparam int LEN_W  = $clog2(15 + 3 * OPND_W);

    typedef struct {
        int unsigned cls;
        int unsigned fmt;
        int unsigned op [3];
        int unsigned vld;
        int unsigned opc;
        int unsigned st;
        int unsigned len;
    } rec_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic [PTR_W-1:0]      start_bit = '0;
    logic [PTR_W-6:0]      mem_addr0, mem_addr1;
    logic [31:0]           mem_rdata0, mem_rdata1;
    logic                  out_valid;
    logic                  out_ready = 1'b0;
    logic [5:0]            out_cls;
    logic [2:0]            out_fmt;
    logic [3*OPND_W-1:0]   out_opnd;
    logic [2:0]            out_opnd_vld;
    logic [4:0]            out_opc;
    logic [PTR_W-1:0]      out_start;
    logic [LEN_W-1:0]      out_len;
    logic                  overrun;

    logic                  mbits [LIM];
    logic [31:0]           wmem  [NWORD];

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    assign mem_rdata0 = wmem[mem_addr0];
    assign mem_rdata1 = wmem[mem_addr1];

    bit_instr_parser #(.PTR_W(PTR_W), .OPND_W(OPND_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_bit    (start_bit),
        .mem_addr0    (mem_addr0),
        .mem_addr1    (mem_addr1),
        .mem_rdata0   (mem_rdata0),
        .mem_rdata1   (mem_rdata1),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_cls      (out_cls),
        .out_fmt      (out_fmt),
        .out_opnd     (out_opnd),
        .out_opnd_vld (out_opnd_vld),
        .out_opc      (out_opc),
        .out_start    (out_start),
        .out_len      (out_len),
        .overrun      (overrun)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // layout from R3
    function automatic int ord_of(int c);
        return c % 4;
    endfunction
    function automatic int olen_of(int c);
        int l = 4 * (c / 4 + 1);
        return (l > 16) ? 16 : l;
    endfunction
    function automatic int opcw_of(int c);
        if (c == 21) return 0;
        if (c < 14) return 2 + c % 3;
        return 5;
    endfunction

    // R1 bit order
    function automatic int unsigned rd(int p, int w);
        int unsigned v = 0;
        for (int i = 0; i < w; i++) begin
            if (mbits[p + i]) v = v | (32'd1 << i);
        end
        return v;
    endfunction

    function automatic bit ref_one(input int p, output rec_t r, output int nxt);
        int q = p;
        int unsigned pre, raw, cid;
        int cw, n, l, ow;
        r.op[0] = 0; r.op[1] = 0; r.op[2] = 0; r.vld = 0;
        r.fmt = 0; r.opc = 0; r.cls = 0; r.st = 0; r.len = 0;
        nxt = p;
        if (q + 4 > LIM) return 0;
        pre = rd(q, 4);
        cw  = (pre >= 14) ? 6 : 4;
        if (q + cw > LIM) return 0;
        raw = rd(q, cw);
        cid = (cw == 4) ? raw : 14 + (raw & 1) * 4 + (raw >> 4);
        r.cls = raw;
        q = q + cw;
        n = ord_of(int'(cid));
        if (q + n > LIM) return 0;
        r.fmt = rd(q, n);
        q = q + n;
        l = olen_of(int'(cid));
        for (int i = 0; i < n; i++) begin
            if (r.fmt[i]) begin
                if (q + l > LIM) return 0;
                r.op[i] = rd(q, l);
                r.vld   = r.vld | (1 << i);
                q = q + l;
            end
        end
        ow = opcw_of(int'(cid));
        if (q + ow > LIM) return 0;
        r.opc = rd(q, ow);
        q = q + ow;
        r.st  = p;
        r.len = q - p;
        nxt   = q;
        return 1;
    endfunction

    task automatic pack_words();
        for (int w = 0; w < NWORD; w++) begin
            for (int b = 0; b < 32; b++) wmem[w][b] = mbits[w * 32 + b];
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < LIM; i++) mbits[i] = 1'($urandom % 2);
    endtask

    task automatic put_bits(input int p, input int w, input int unsigned v);
        for (int i = 0; i < w; i++) mbits[p + i] = v[i];
    endtask

    task automatic compare(input rec_t e, input bit held);
        if (held) chk("R6", "held start", out_start, e.st);
        chk("R2", "class", out_cls, e.cls);
        chk("R3", "format", out_fmt, e.fmt);
        for (int i = 0; i < 3; i++) chk("R1", "operand", out_opnd[i*OPND_W +: OPND_W], e.op[i]);
        chk("R4", "operand flags", out_opnd_vld, e.vld);
        chk("R3", "opcode", out_opc, e.opc);
        chk("R5", "start bit", out_start, e.st);
        chk("R5", "length", out_len, e.len);
    endtask

    task automatic run_stream(input int sp, input int abort_at);
        rec_t exp_q[$];
        rec_t r;
        int p, nxt, k;
        bit held;
        p = sp;
        while (ref_one(p, r, nxt)) begin
            exp_q.push_back(r);
            p = nxt;
        end
        @(negedge clk);
        start = 1'b1; start_bit = PTR_W'(sp); out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "valid right after start", out_valid, 0);
        chk("R8", "overrun right after start", overrun, 0);
        k = 0; held = 0;
        forever begin
            if (out_valid) begin
                if (k >= exp_q.size()) begin
                    chk("R5", "record beyond expected", k, exp_q.size() - 1);
                    break;
                end
                compare(exp_q[k], held);
                if (abort_at == k) begin
                    out_ready = 1'b0;
                    break;
                end
                out_ready = ($urandom % 4) != 0;
                held = !out_ready;
                if (out_ready) k = k + 1;
            end else if (overrun) begin
                chk("R7", "records before overrun", k, exp_q.size());
                out_ready = 1'b0;
                break;
            end else begin
                out_ready = 1'($urandom % 2);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0432));
        fill_random();
        pack_words();
        repeat (3) @(negedge clk);
        chk("R9", "valid in reset", out_valid, 0);
        chk("R9", "overrun in reset", overrun, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9", "valid idle", out_valid, 0);
        chk("R9", "overrun idle", overrun, 0);

        // R7 instruction ending exactly on the last bit: class 0, 2-bit opcode
        put_bits(LIM - 6, 4, 0);
        put_bits(LIM - 2, 2, 2);
        pack_words();
        run_stream(LIM - 6, -1);

        // R7 overrun inside an operand: class id 15, all explicit
        put_bits(LIM - 20, 6, 6'h1E);
        put_bits(LIM - 14, 3, 3'b111);
        pack_words();
        run_stream(LIM - 20, -1);

        // R1 class straddling a word boundary, extended class id 21
        fill_random();
        put_bits(29, 6, 6'h3F);
        put_bits(35, 1, 1);
        put_bits(36, 16, 16'hA5C3);
        pack_words();
        run_stream(29, -1);

        // R4 all-implicit operands: class id 3, format 000
        fill_random();
        put_bits(200, 4, 3);
        put_bits(204, 3, 0);
        pack_words();
        run_stream(200, -1);

        // R8 restart while a record is pending
        fill_random();
        pack_words();
        run_stream(100, 3);
        run_stream(517, -1);

        for (int t = 0; t < 10; t++) begin
            fill_random();
            pack_words();
            run_stream(int'($urandom % LIM), -1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule